// File: doc/BRIEF.md
# Paired Byte Register File

This block holds the working registers of a small 8-bit datapath. Six byte registers, called B, C, D, E, H and L here, can be read and written one at a time. They are also grouped in fixed pairs, BC, DE and HL, so that a pair can be read, written, incremented or decremented as one 16-bit word. In each pair the first-named register is the high byte. Any pair can drive a 16-bit address output as a memory pointer, and HL is the default pointer.

The file also holds a 16-bit stack pointer and a 16-bit program counter. The stack pointer moves by two on each push or pop request. The program counter takes a parallel load or counts up by one. All reads are combinational. All writes take effect on the rising clock edge. An active-low reset clears every register to zero. The block has no states: each register updates from its own request lines in every cycle. It has one operating condition, running, and one transition, out of reset.

Top module: `paired_regfile`

## Requirements
- R1: A byte write (`byte_we`) stores `byte_wdata` in the register chosen by `byte_wsel`, with code 0=B, 1=C, 2=D, 3=E, 4=H, 5=L. `byte_rdata` shows the register chosen by `byte_rsel` using the same codes.
- R2: `pair_rdata` shows the pair chosen by `pair_rsel`, with code 0=BC, 1=DE, 2=HL and 3=stack pointer. In each pair, B, D or H is bits 15:8 and C, E or L is bits 7:0.
- R3: A byte write changes only the register it names. The other register of the same pair keeps its value.
- R4: A pair write (`pair_we`, `pair_wsel` using the codes 0 to 2 from R2) loads both bytes of the pair at the same clock edge.
- R5: `addr` shows the pair chosen by `ptr_sel`, with code 0=BC, 1=DE and 2=HL. Code 3 selects HL, the default pointer.
- R6: `pair_inc` adds one to the pair chosen by `pair_ssel`, and `pair_dec` subtracts one. The carry or borrow passes from the low byte into the high byte, and the result wraps modulo 2^16. When both are set, the pair does not change.
- R7: `sp_push` alone lowers the stack pointer by 2, and `sp_pop` alone raises it by 2. Both wrap modulo 2^16. When both are set, or neither, the stack pointer holds its value.
- R8: `pc_load` loads `pc_din` into the program counter. `pc_inc` adds one. Load wins when both are requested.
- R9: While `rst_n` is low, all six byte registers, the stack pointer and the program counter clear to zero.
- R10: When several updates hit the same pair in one cycle, the pair write wins over the increment or decrement, and the increment or decrement wins over the byte write.
- R11: Byte codes 6 and 7 name no register. They read as zero, and a write with either code changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| byte_we | input | 1 | Byte write enable |
| byte_wsel | input | 3 | Byte write register code |
| byte_wdata | input | 8 | Byte write data |
| byte_rsel | input | 3 | Byte read register code |
| byte_rdata | output | 8 | Byte read data |
| pair_we | input | 1 | Pair write enable |
| pair_wsel | input | 2 | Pair write code |
| pair_wdata | input | 16 | Pair write data |
| pair_inc | input | 1 | Pair increment request |
| pair_dec | input | 1 | Pair decrement request |
| pair_ssel | input | 2 | Pair code for increment or decrement |
| pair_rsel | input | 2 | Pair read code |
| pair_rdata | output | 16 | Pair read data |
| ptr_sel | input | 2 | Pointer pair code for the address output |
| addr | output | 16 | Memory pointer output |
| sp_push | input | 1 | Push request, stack pointer minus 2 |
| sp_pop | input | 1 | Pop request, stack pointer plus 2 |
| sp_q | output | 16 | Stack pointer value |
| pc_load | input | 1 | Program counter load |
| pc_inc | input | 1 | Program counter increment |
| pc_din | input | 16 | Program counter load value |
| pc_q | output | 16 | Program counter value |

## Verification
The bench writes each byte code in turn and reads the pair that contains it. A design with the byte order swapped, or one that clears or copies the partner byte on a byte write, shows the wrong 16-bit value. It steps pairs across 00FF, FFFF and 0000. A missing carry into the high byte gives 0000 where 0100 is expected, and a bad wrap leaves the value stuck at the boundary. It also tests a stack pointer that moves by one, or moves when push and pop arrive together. It tests a program counter that lets increment beat load, a pointer mux that sends code 3 to the wrong pair, and unused byte codes that write into a real register.

// File: rtl/paired_rf_pkg.sv
package paired_rf_pkg;
    typedef enum logic [1:0] {
        PAIR_BC  = 2'd0,
        PAIR_DE  = 2'd1,
        PAIR_HL  = 2'd2,
        PAIR_ALT = 2'd3
    } pair_code_e;

    localparam int NUM_PAIRS = 3;
endpackage

// File: rtl/paired_rf_pair.sv
module paired_rf_pair #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_we,
    input  logic            lo_we,
    input  logic [BW-1:0]   byte_d,
    input  logic            word_we,
    input  logic [2*BW-1:0] word_d,
    input  logic            step_up,
    input  logic            step_dn,
    output logic [2*BW-1:0] q
);
    localparam int WW = 2 * BW;

    // Word write over step over byte write (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (word_we) begin
            q <= word_d;
        end else if (step_up && !step_dn) begin
            q <= q + WW'(1);
        end else if (step_dn && !step_up) begin
            q <= q - WW'(1);
        end else begin
            if (hi_we) q[WW-1:BW] <= byte_d;
            if (lo_we) q[BW-1:0]  <= byte_d;
        end
    end
endmodule

// File: rtl/paired_rf_sp.sv
module paired_rf_sp #(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [WW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   q <= q - WW'(2);
                2'b01:   q <= q + WW'(2);
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/paired_rf_pc.sv
module paired_rf_pc #(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          inc,
    input  logic [WW-1:0] din,
    output logic [WW-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (inc) begin
            q <= q + WW'(1);
        end
    end
endmodule

// File: rtl/paired_regfile.sv
module paired_regfile #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_we,
    input  logic [2:0]      byte_wsel,
    input  logic [BW-1:0]   byte_wdata,
    input  logic [2:0]      byte_rsel,
    output logic [BW-1:0]   byte_rdata,
    input  logic            pair_we,
    input  logic [1:0]      pair_wsel,
    input  logic [2*BW-1:0] pair_wdata,
    input  logic            pair_inc,
    input  logic            pair_dec,
    input  logic [1:0]      pair_ssel,
    input  logic [1:0]      pair_rsel,
    output logic [2*BW-1:0] pair_rdata,
    input  logic [1:0]      ptr_sel,
    output logic [2*BW-1:0] addr,
    input  logic            sp_push,
    input  logic            sp_pop,
    output logic [2*BW-1:0] sp_q,
    input  logic            pc_load,
    input  logic            pc_inc,
    input  logic [2*BW-1:0] pc_din,
    output logic [2*BW-1:0] pc_q
);
    import paired_rf_pkg::*;

    localparam int WW = 2 * BW;

    logic [WW-1:0] pq [NUM_PAIRS];
    logic [WW-1:0] bc_q;
    logic [WW-1:0] de_q;
    logic [WW-1:0] hl_q;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic hi_we;
        logic lo_we;
        logic wd_we;
        logic up;
        logic dn;

        // High byte has the even code, low byte the odd code (R1)
        assign hi_we = byte_we && (byte_wsel == 3'(2 * g));
        assign lo_we = byte_we && (byte_wsel == 3'(2 * g + 1));
        assign wd_we = pair_we && (pair_wsel == 2'(g));
        assign up    = pair_inc && (pair_ssel == 2'(g));
        assign dn    = pair_dec && (pair_ssel == 2'(g));

        paired_rf_pair #(.BW(BW)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .hi_we   (hi_we),
            .lo_we   (lo_we),
            .byte_d  (byte_wdata),
            .word_we (wd_we),
            .word_d  (pair_wdata),
            .step_up (up),
            .step_dn (dn),
            .q       (pq[g])
        );
    end

    assign bc_q = pq[0];
    assign de_q = pq[1];
    assign hl_q = pq[2];

    paired_rf_sp #(.WW(WW)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sp_push),
        .pop   (sp_pop),
        .q     (sp_q)
    );

    paired_rf_pc #(.WW(WW)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pc_load),
        .inc   (pc_inc),
        .din   (pc_din),
        .q     (pc_q)
    );

    // Byte read, unused codes give zero (R11)
    always_comb begin
        unique case (byte_rsel)
            3'd0:    byte_rdata = bc_q[WW-1:BW];
            3'd1:    byte_rdata = bc_q[BW-1:0];
            3'd2:    byte_rdata = de_q[WW-1:BW];
            3'd3:    byte_rdata = de_q[BW-1:0];
            3'd4:    byte_rdata = hl_q[WW-1:BW];
            3'd5:    byte_rdata = hl_q[BW-1:0];
            default: byte_rdata = '0;
        endcase
    end

    always_comb begin
        unique case (pair_code_e'(pair_rsel))
            PAIR_BC:  pair_rdata = bc_q;
            PAIR_DE:  pair_rdata = de_q;
            PAIR_HL:  pair_rdata = hl_q;
            PAIR_ALT: pair_rdata = sp_q;
            default:  pair_rdata = '0;
        endcase
    end

    // Pointer mux, alternate code falls back to HL (R5)
    always_comb begin
        unique case (pair_code_e'(ptr_sel))
            PAIR_BC:  addr = bc_q;
            PAIR_DE:  addr = de_q;
            PAIR_HL:  addr = hl_q;
            PAIR_ALT: addr = hl_q;
            default:  addr = hl_q;
        endcase
    end
endmodule

// File: rtl/paired_regfile_chk.sv
module paired_regfile_chk #(
    parameter int BW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            byte_we,
    input logic [2:0]      byte_wsel,
    input logic [BW-1:0]   byte_wdata,
    input logic            pair_we,
    input logic [1:0]      pair_wsel,
    input logic [2*BW-1:0] pair_wdata,
    input logic            pair_inc,
    input logic            pair_dec,
    input logic [1:0]      pair_ssel,
    input logic [1:0]      ptr_sel,
    input logic [2*BW-1:0] addr,
    input logic            sp_push,
    input logic            sp_pop,
    input logic [2*BW-1:0] sp_q,
    input logic            pc_load,
    input logic            pc_inc,
    input logic [2*BW-1:0] pc_din,
    input logic [2*BW-1:0] pc_q,
    input logic [2*BW-1:0] bc_q,
    input logic [2*BW-1:0] hl_q
);
    localparam int WW = 2 * BW;

    logic bc_busy;
    assign bc_busy = (pair_we && pair_wsel == 2'd0)
                  || (pair_ssel == 2'd0 && (pair_inc ^ pair_dec));

    p_partner_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && byte_wsel == 3'd1 && !bc_busy)
        |=> (bc_q[WW-1:BW] == $past(bc_q[WW-1:BW]) && bc_q[BW-1:0] == $past(byte_wdata)));

    p_pair_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we && pair_wsel == 2'd0) |=> (bc_q == $past(pair_wdata)));

    p_default_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sel == 2'd3) |-> (addr == hl_q));

    p_hl_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_inc && !pair_dec && pair_ssel == 2'd2 && !(pair_we && pair_wsel == 2'd2))
        |=> (hl_q == $past(hl_q) + WW'(1)));

    p_sp_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_push && !sp_pop) |=> (sp_q == $past(sp_q) - WW'(2)));

    p_sp_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_pop && !sp_push) |=> (sp_q == $past(sp_q) + WW'(2)));

    p_sp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_pop == sp_push) |=> $stable(sp_q));

    p_pc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> (pc_q == $past(pc_din)));

    p_pc_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !pc_load) |=> (pc_q == $past(pc_q) + WW'(1)));
endmodule

bind paired_regfile paired_regfile_chk #(.BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_we    (byte_we),
    .byte_wsel  (byte_wsel),
    .byte_wdata (byte_wdata),
    .pair_we    (pair_we),
    .pair_wsel  (pair_wsel),
    .pair_wdata (pair_wdata),
    .pair_inc   (pair_inc),
    .pair_dec   (pair_dec),
    .pair_ssel  (pair_ssel),
    .ptr_sel    (ptr_sel),
    .addr       (addr),
    .sp_push    (sp_push),
    .sp_pop     (sp_pop),
    .sp_q       (sp_q),
    .pc_load    (pc_load),
    .pc_inc     (pc_inc),
    .pc_din     (pc_din),
    .pc_q       (pc_q),
    .bc_q       (bc_q),
    .hl_q       (hl_q)
);

// File: tb/paired_regfile_bench.sv
module paired_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_we;
    logic [2:0]  byte_wsel;
    logic [7:0]  byte_wdata;
    logic [2:0]  byte_rsel;
    logic [7:0]  byte_rdata;
    logic        pair_we;
    logic [1:0]  pair_wsel;
    logic [15:0] pair_wdata;
    logic        pair_inc;
    logic        pair_dec;
    logic [1:0]  pair_ssel;
    logic [1:0]  pair_rsel;
    logic [15:0] pair_rdata;
    logic [1:0]  ptr_sel;
    logic [15:0] addr;
    logic        sp_push;
    logic        sp_pop;
    logic [15:0] sp_q;
    logic        pc_load;
    logic        pc_inc;
    logic [15:0] pc_din;
    logic [15:0] pc_q;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    paired_regfile u_paired_regfile (.*);

    // {byte code, byte data, pair code, expected pair}
    localparam logic [28:0] VEC [8] = '{
        {3'd0, 8'h12, 2'd0, 16'h1200},
        {3'd1, 8'h34, 2'd0, 16'h1234},
        {3'd2, 8'h56, 2'd1, 16'h5600},
        {3'd3, 8'h78, 2'd1, 16'h5678},
        {3'd4, 8'h9A, 2'd2, 16'h9A00},
        {3'd5, 8'hBC, 2'd2, 16'h9ABC},
        {3'd1, 8'hFF, 2'd0, 16'h12FF},
        {3'd4, 8'h01, 2'd2, 16'h01BC}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        byte_we = 0; pair_we = 0; pair_inc = 0; pair_dec = 0;
        sp_push = 0; sp_pop = 0; pc_load = 0; pc_inc = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic rd_pair(input logic [1:0] s, output logic [15:0] v);
        pair_rsel = s;
        #1 v = pair_rdata;
    endtask

    task automatic wr_pair(input logic [1:0] s, input logic [15:0] d);
        pair_we = 1; pair_wsel = s; pair_wdata = d;
        tick();
    endtask

    task automatic step(input logic up, input logic [1:0] s);
        pair_inc = up; pair_dec = !up; pair_ssel = s;
        tick();
    endtask

    task automatic check_all_zero(input string req);
        logic [15:0] v;
        for (int p = 0; p < 3; p++) begin
            rd_pair(2'(p), v);
            chk(req, v, 16'h0000);
        end
        chk(req, sp_q, 16'h0000);
        chk(req, pc_q, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        rst_n = 0;
        idle();
        byte_wsel = 0; byte_wdata = 0; byte_rsel = 0;
        pair_wsel = 0; pair_wdata = 0; pair_ssel = 0; pair_rsel = 0;
        ptr_sel = 0; pc_din = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9 reset state
        check_all_zero("R9 reset");
        chk("R9 reset addr", addr, 16'h0000);

        // R1 R2 R3 table walk
        for (int i = 0; i < 8; i++) begin
            byte_we = 1;
            byte_wsel = VEC[i][28:26];
            byte_wdata = VEC[i][25:18];
            tick();
            byte_rsel = VEC[i][28:26];
            #1 chk("R1 byte readback", {8'h00, byte_rdata}, {8'h00, VEC[i][25:18]});
            rd_pair(VEC[i][17:16], v);
            chk("R2 R3 pair view", v, VEC[i][15:0]);
        end

        // R5 pointer select
        ptr_sel = 2'd0; #1 chk("R5 ptr BC", addr, 16'h12FF);
        ptr_sel = 2'd1; #1 chk("R5 ptr DE", addr, 16'h5678);
        ptr_sel = 2'd2; #1 chk("R5 ptr HL", addr, 16'h01BC);
        ptr_sel = 2'd3; #1 chk("R5 ptr default HL", addr, 16'h01BC);

        // R11 unused byte codes
        byte_we = 1; byte_wsel = 3'd6; byte_wdata = 8'hAA; tick();
        byte_we = 1; byte_wsel = 3'd7; byte_wdata = 8'h55; tick();
        rd_pair(2'd0, v); chk("R11 BC untouched", v, 16'h12FF);
        rd_pair(2'd1, v); chk("R11 DE untouched", v, 16'h5678);
        rd_pair(2'd2, v); chk("R11 HL untouched", v, 16'h01BC);
        byte_rsel = 3'd6; #1 chk("R11 code 6 reads zero", {8'h00, byte_rdata}, 16'h0000);
        byte_rsel = 3'd7; #1 chk("R11 code 7 reads zero", {8'h00, byte_rdata}, 16'h0000);

        // R4 pair write, both bytes
        wr_pair(2'd1, 16'hBEEF);
        byte_rsel = 3'd2; #1 chk("R4 D byte", {8'h00, byte_rdata}, 16'h00BE);
        byte_rsel = 3'd3; #1 chk("R4 E byte", {8'h00, byte_rdata}, 16'h00EF);

        // R6 stepping with carry and wrap
        wr_pair(2'd2, 16'h00FF);
        step(1'b1, 2'd2); rd_pair(2'd2, v); chk("R6 carry into high", v, 16'h0100);
        step(1'b0, 2'd2); rd_pair(2'd2, v); chk("R6 borrow from high", v, 16'h00FF);
        wr_pair(2'd2, 16'hFFFF);
        step(1'b1, 2'd2); rd_pair(2'd2, v); chk("R6 wrap up", v, 16'h0000);
        step(1'b0, 2'd2); rd_pair(2'd2, v); chk("R6 wrap down", v, 16'hFFFF);
        pair_inc = 1; pair_dec = 1; pair_ssel = 2'd2; tick();
        rd_pair(2'd2, v); chk("R6 inc and dec hold", v, 16'hFFFF);

        // R7 stack pointer
        sp_push = 1; tick(); chk("R7 push wrap", sp_q, 16'hFFFE);
        sp_push = 1; tick(); chk("R7 push", sp_q, 16'hFFFC);
        sp_pop = 1; tick(); chk("R7 pop", sp_q, 16'hFFFE);
        sp_push = 1; sp_pop = 1; tick(); chk("R7 both hold", sp_q, 16'hFFFE);
        sp_pop = 1; tick(); chk("R7 pop wrap", sp_q, 16'h0000);
        sp_push = 1; tick(); rd_pair(2'd3, v); chk("R2 pair code 3 is SP", v, 16'hFFFE);

        // R8 program counter
        pc_inc = 1; tick(); chk("R8 inc", pc_q, 16'h0001);
        pc_load = 1; pc_inc = 1; pc_din = 16'h1234; tick(); chk("R8 load wins", pc_q, 16'h1234);
        pc_inc = 1; tick(); chk("R8 inc after load", pc_q, 16'h1235);

        // R10 same-pair priority
        pair_we = 1; pair_wsel = 2'd0; pair_wdata = 16'hAAAA;
        byte_we = 1; byte_wsel = 3'd0; byte_wdata = 8'h11;
        pair_inc = 1; pair_ssel = 2'd0;
        tick(); rd_pair(2'd0, v); chk("R10 word write wins", v, 16'hAAAA);
        pair_inc = 1; pair_ssel = 2'd0;
        byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'h00;
        tick(); rd_pair(2'd0, v); chk("R10 step beats byte", v, 16'hAAAB);
        pair_inc = 1; pair_ssel = 2'd1;
        byte_we = 1; byte_wsel = 3'd1; byte_wdata = 8'h00;
        tick();
        rd_pair(2'd0, v); chk("R10 R3 other pair byte", v, 16'hAA00);
        rd_pair(2'd1, v); chk("R10 other pair step", v, 16'hBEF0);

        // R9 reset in mid-run
        rst_n = 0;
        @(negedge clk);
        check_all_zero("R9 mid-run reset");
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule